// File: doc/BRIEF.md
# Twisted-Pair Collision Detector

This block watches the transmit-active and receive-active indications of a 10 Mb/s twisted-pair port and raises an internal collision flag whenever both are active together. The flag remains set for as long as the overlap lasts. After the overlap ends, a timer keeps the flag set for a programmable number of bit times (two by default), counted on a one-cycle-per-bit clock enable. The flag is meant to be routed on to status LEDs and to the MAC.

Link health gates every indication. While the link is failed, the collision flag and the gated transmit and receive activity outputs are all held low. A transmit attempt made while the link is failed does not count as a collision. Instead it sets two sticky fault bits, one for loss of carrier and one for collision error. These bits stay set until a dedicated clear input or reset removes them.

Top module: `tp_collision_detect`

## Requirements
- R1: When `tx_act`, `rx_act` and `link_pass` are all 1 at a rising edge, `col` is 1 in the cycle after that edge, provided `link_pass` is still 1.
- R2: `col` stays 1 on every cycle that follows an edge at which the overlap is still present.
- R3: After the overlap ends, `col` stays 1 until `HOLD_BITS` (default 2) edges have sampled `bit_en`=1 with no overlap. Counting starts at the first edge with no overlap. `col` is 0 from the cycle after the edge that counts the last strobe.
- R4: A new overlap during the extension reloads the full `HOLD_BITS` count. `col` shows no 0 cycle between the two collisions.
- R5: While `link_pass` is 0, `col`, `tx_ind` and `rx_ind` are 0 in the same cycle. Any extension in progress is discarded, so `col` stays 0 when the link returns unless a new overlap is seen.
- R6: An edge with `tx_act`=1 and `link_pass`=0 sets both `loss_carrier` and `coll_err` to 1 from the next cycle on.
- R7: `loss_carrier` and `coll_err` are sticky. They are cleared by an edge with `flag_clr`=1. If a set condition and `flag_clr` occur at the same edge, the set wins.
- R8: An edge with `rst`=1 clears `col`, the extension timer and both sticky flags. `col` stays 0 after reset until a new overlap is seen.
- R9: While `link_pass` is 1, `tx_ind` equals `tx_act` and `rx_ind` equals `rx_act` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per bit time |
| tx_act | input | 1 | Transmit data active on the pair |
| rx_act | input | 1 | Receive data active on the pair |
| link_pass | input | 1 | 1 = link pass, 0 = link fail |
| flag_clr | input | 1 | Clears both sticky fault flags |
| col | output | 1 | Collision flag, stretched after the overlap |
| tx_ind | output | 1 | Link-gated transmit activity |
| rx_ind | output | 1 | Link-gated receive activity |
| loss_carrier | output | 1 | Sticky loss-of-carrier fault |
| coll_err | output | 1 | Sticky collision-error fault |

## Verification
A wrong extension count or a bad reload shows up on `col` within a few bit times of an overlap ending. It appears as an early drop, a late drop or a one-cycle gap between back-to-back collisions. A stale timer left over across a link failure or a reset shows up as `col` rising with no overlap in the first cycle after the link returns. Faults in the sticky flags show up one cycle after a failed-link transmit or a clear. The bench compares every output against a behavioural model on every cycle, so each of these errors is reported in the cycle it first appears.

// File: rtl/tpcd_pkg.sv
package tpcd_pkg;
   // upper bound on the extension length accepted at elaboration
   localparam int unsigned TPCD_MAX_HOLD = 255;

   typedef struct packed {
      logic no_carrier;
      logic coll_fault;
   } fault_flags_t;
endpackage

// File: rtl/tpcd_hold_timer.sv
module tpcd_hold_timer #(
   parameter int unsigned HOLD_BITS = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic load,
   input  logic flush,
   output logic busy
);
   import tpcd_pkg::*;

   if (HOLD_BITS > TPCD_MAX_HOLD) begin : g_bad_hold
      $error("tpcd_hold_timer: HOLD_BITS above supported maximum");
   end

   if (HOLD_BITS == 0) begin : g_no_hold
      assign busy = 1'b0;
   end else begin : g_hold
      localparam int unsigned CNT_W = $clog2(HOLD_BITS + 1);
      localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_BITS);

      logic [CNT_W-1:0] remain_q;

      always_ff @(posedge clk) begin
         if (rst || flush) begin
            remain_q <= '0;
         end else if (load) begin
            remain_q <= RELOAD;
         end else if (bit_en && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
         end
      end

      assign busy = (remain_q != '0);

      // R3
      hold_countdown_chk: assert property (@(posedge clk) disable iff (rst)
         (!load && !flush && busy) |=> (remain_q <= $past(remain_q)));
      // R4
      hold_reload_chk: assert property (@(posedge clk) disable iff (rst)
         (load && !flush) |=> (remain_q == RELOAD));
   end
endmodule

// File: rtl/tpcd_fault_flags.sv
module tpcd_fault_flags #(
   parameter bit SET_OVER_CLEAR = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   tx_act,
   input  logic                   link_pass,
   input  logic                   clr,
   output tpcd_pkg::fault_flags_t flags
);
   import tpcd_pkg::*;

   fault_flags_t flags_q;
   logic         fail_attempt;

   assign fail_attempt = tx_act && !link_pass;

   if (SET_OVER_CLEAR) begin : g_set_wins
      always_ff @(posedge clk) begin
         if (rst)               flags_q <= '0;
         else if (fail_attempt) flags_q <= '1;
         else if (clr)          flags_q <= '0;
      end
   end else begin : g_clr_wins
      always_ff @(posedge clk) begin
         if (rst)               flags_q <= '0;
         else if (clr)          flags_q <= '0;
         else if (fail_attempt) flags_q <= '1;
      end
   end

   assign flags = flags_q;

   // R6
   fail_tx_sets_chk: assert property (@(posedge clk) disable iff (rst)
      (fail_attempt && (SET_OVER_CLEAR || !clr)) |=> (flags.no_carrier && flags.coll_fault));
   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (flags.no_carrier && !clr) |=> flags.no_carrier);
endmodule

// File: rtl/tp_collision_detect.sv
module tp_collision_detect #(
   parameter int unsigned HOLD_BITS      = 2,
   parameter bit          SET_OVER_CLEAR = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic tx_act,
   input  logic rx_act,
   input  logic link_pass,
   input  logic flag_clr,
   output logic col,
   output logic tx_ind,
   output logic rx_ind,
   output logic loss_carrier,
   output logic coll_err
);
   import tpcd_pkg::*;

   logic         overlap;
   logic         overlap_q;
   logic         hold_busy;
   fault_flags_t faults;

   assign overlap = tx_act && rx_act && link_pass;

   always_ff @(posedge clk) begin
      if (rst) overlap_q <= 1'b0;
      else     overlap_q <= overlap;
   end

   tpcd_hold_timer #(.HOLD_BITS(HOLD_BITS)) hold_i (
      .clk    (clk),
      .rst    (rst),
      .bit_en (bit_en),
      .load   (overlap),
      .flush  (!link_pass),
      .busy   (hold_busy)
   );

   tpcd_fault_flags #(.SET_OVER_CLEAR(SET_OVER_CLEAR)) flags_i (
      .clk       (clk),
      .rst       (rst),
      .tx_act    (tx_act),
      .link_pass (link_pass),
      .clr       (flag_clr),
      .flags     (faults)
   );

   assign col          = link_pass && (overlap_q || hold_busy);
   assign tx_ind       = link_pass && tx_act;
   assign rx_ind       = link_pass && rx_act;
   assign loss_carrier = faults.no_carrier;
   assign coll_err     = faults.coll_fault;

   // R1
   overlap_raises_col_chk: assert property (@(posedge clk) disable iff (rst)
      overlap |=> (col || !link_pass));
   // R5
   link_fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !link_pass |-> (!col && !tx_ind && !rx_ind));
   // R5
   no_stale_col_chk: assert property (@(posedge clk) disable iff (rst)
      (!link_pass && !overlap) |=> !col);
endmodule

// File: tb/tp_collision_detect_tb_top.sv
module tp_collision_detect_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1, bit_en = 1'b0, tx_act = 1'b0, rx_act = 1'b0;
   logic link_pass = 1'b0, flag_clr = 1'b0;
   logic col, tx_ind, rx_ind, loss_carrier, coll_err;

   int n_checks = 0;
   int n_fail   = 0;

   // behavioural reference state
   bit m_ovl  = 1'b0;
   int m_left = 0;
   bit m_lcar = 1'b0;
   bit m_cerr = 1'b0;

   always #2.5 clk = ~clk;

   tp_collision_detect dut_i (
      .clk(clk), .rst(rst), .bit_en(bit_en), .tx_act(tx_act), .rx_act(rx_act),
      .link_pass(link_pass), .flag_clr(flag_clr), .col(col), .tx_ind(tx_ind),
      .rx_ind(rx_ind), .loss_carrier(loss_carrier), .coll_err(coll_err)
   );

   task automatic check1(input string tag, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // drive one cycle, compare every output, then advance the model at the edge
   task automatic step(input string tag, input bit r, input bit t, input bit x,
                       input bit l, input bit b, input bit c);
      rst = r; tx_act = t; rx_act = x; link_pass = l; bit_en = b; flag_clr = c;
      #1;
      if (!r) begin
         check1(tag, "col", col, l && (m_ovl || m_left > 0));
         check1(tag, "tx_ind (R9)", tx_ind, l && t);
         check1(tag, "rx_ind (R9)", rx_ind, l && x);
      end
      check1(tag, "loss_carrier", loss_carrier, m_lcar);
      check1(tag, "coll_err", coll_err, m_cerr);
      @(posedge clk);
      if (r) begin
         m_ovl = 0; m_left = 0; m_lcar = 0; m_cerr = 0;
      end else begin
         if (!l)              m_left = 0;
         else if (t && x)     m_left = 2;
         else if (b && m_left > 0) m_left = m_left - 1;
         m_ovl = t && x && l;
         if (t && !l) begin m_lcar = 1; m_cerr = 1; end
         else if (c)  begin m_lcar = 0; m_cerr = 0; end
      end
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      bit [15:0] lfsr = 16'hACE1;
      @(negedge clk);
      // R8 reset state
      repeat (3) step("R8", 1, 0, 0, 1, 0, 0);
      step("R8", 0, 0, 0, 1, 0, 0);
      // R9 single-sided activity
      step("R9", 0, 1, 0, 1, 1, 0);
      step("R9", 0, 0, 1, 1, 1, 0);
      // R1 and R2 overlap held
      repeat (4) step("R1", 0, 1, 1, 1, 0, 0);
      repeat (2) step("R2", 0, 1, 1, 1, 1, 0);
      // R3 extension with sparse bit strobes
      for (int i = 0; i < 10; i++) step("R3", 0, 0, 1, 1, (i % 3) == 2, 0);
      // R3 strobe on first idle edge
      step("R3", 0, 1, 1, 1, 0, 0);
      for (int i = 0; i < 4; i++) step("R3", 0, 1, 0, 1, 1, 0);
      // R4 new overlap mid-extension
      step("R4", 0, 1, 1, 1, 0, 0);
      step("R4", 0, 0, 0, 1, 1, 0);
      step("R4", 0, 1, 1, 1, 1, 0);
      for (int i = 0; i < 5; i++) step("R4", 0, 0, 0, 1, 1, 0);
      // R5 link drop during extension, then link returns
      step("R5", 0, 1, 1, 1, 0, 0);
      step("R5", 0, 1, 1, 0, 0, 0);
      step("R5", 0, 0, 1, 0, 1, 0);
      repeat (3) step("R5", 0, 0, 0, 1, 0, 0);
      // R6 transmit attempt while link failed
      step("R6", 0, 1, 0, 0, 0, 0);
      repeat (3) step("R7", 0, 0, 0, 1, 1, 0);
      step("R7", 0, 0, 0, 1, 0, 1);
      step("R7", 0, 0, 0, 1, 0, 0);
      // R7 set and clear on the same edge
      step("R7", 0, 1, 1, 0, 0, 1);
      step("R7", 0, 0, 0, 1, 0, 0);
      step("R7", 0, 0, 0, 1, 0, 1);
      // R8 reset during extension and with flags set
      step("R8", 0, 1, 0, 0, 0, 0);
      step("R8", 0, 1, 1, 1, 0, 0);
      step("R8", 1, 0, 0, 1, 0, 0);
      repeat (3) step("R8", 0, 0, 0, 1, 1, 0);
      // mixed pattern
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step("R3", lfsr[11:0] == 0, lfsr[0] | lfsr[5], lfsr[1] | lfsr[6],
              lfsr[9:7] != 0, lfsr[2], lfsr[10:8] == 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule